// File: doc/BRIEF.md
# Capacitive baseline tracking calibrator

This block sits after a capacitance measurement front end. For every key channel it takes the latest 7-bit reading, turns it into a working value (127 minus the reading) and compares that value with a stored baseline kept in the same working domain. A channel counts as touched when its working value rises above the baseline by more than that channel's touch margin. A smaller environmental margin, shared by all channels, sets the band inside which a rise is treated as slow drift and not as a finger.

The baseline follows the environment. A reading that falls below the baseline pulls the baseline down on the same sample. A small rise is absorbed only at an automatic calibration point. A rise above the environmental margin leaves the baseline frozen. Automatic calibration points come from two timers that count sensor clock ticks. The first point comes after a quiet period in which no channel was touched. Further points follow at a fixed interval for as long as no channel is touched. A freeze control stops all automatic tracking. While frozen, the host may ask for a forced recalibration of every channel, either unconditionally or only when no channel is touched. Every calibration produces a one-cycle end-of-calibration pulse and sets a sticky event flag. The flag drives an interrupt output that can be masked, and the host clears it with a clear strobe.

Top module: `cap_base_cal`

## Requirements
- R1: After reset, all touch flags, the event pulse, the event flag and both request-pending flags are 0, and every baseline output reads 127 (raw domain). The first sample strobe after reset loads every baseline with its own reading and reports no touch.
- R2: On a sample strobe, channel c's touch flag becomes 1 when (127 - reading) > baseline + margin_c, with the sum formed in 8 bits. When the working value equals baseline + margin_c, the flag is 0. The flag is valid one clock after the strobe.
- R3: A channel whose working value exceeds baseline + environmental margin keeps its baseline unchanged on any sample that is not a forced recalibration, including an automatic calibration sample.
- R4: With the freeze control at 0, a sample whose working value is below the baseline sets that baseline to the working value on the same strobe, whether or not a calibration is due.
- R5: At an automatic calibration sample, each channel whose working value lies above the baseline but not above baseline + environmental margin has its baseline set to the working value. On any other sample such a rise leaves the baseline unchanged.
- R6: An automatic calibration becomes due once no channel has been touched for wait_cfg × 64 sensor ticks. Any touched sample restarts that count and cancels a due calibration. The due calibration is applied on the next sample strobe.
- R7: After the first automatic calibration point, and while no touch occurs, a further point becomes due every interval_cfg × 50 sensor ticks.
- R8: With the freeze control at 1, no automatic calibration takes place, no snap-down takes place and no end-of-calibration event is raised by the timers.
- R9: An unconditional request strobe issued while frozen sets its pending flag. The next sample strobe then loads every baseline with its working value, raises the event and clears the flag. A request strobe issued while not frozen is ignored (pending flag stays 0).
- R10: A conditional request pending while frozen is applied only on a sample strobe in which no channel is touched, and it then loads every baseline. On a touched sample it stays pending and the baselines are unchanged.
- R11: Each calibration (automatic or forced) gives a one-cycle end-of-calibration pulse one clock after its strobe and sets the event flag. A clear strobe resets the flag on the next clock. The interrupt output equals the flag while the mask input is 0 and is 0 while the mask input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | One-cycle strobe marking a new set of readings |
| smp_raw | input | NCH*VW (21) | Raw readings, channel c in bits [c*VW +: VW] |
| sens_tick | input | 1 | One-cycle sensor clock tick for the timers |
| cfg_tvr | input | NCH*VW (21) | Per-channel touch margin, channel c in bits [c*VW +: VW] |
| cfg_evr | input | VW (7) | Shared environmental margin |
| cfg_wait | input | CW (8) | Quiet period, in units of 64 ticks |
| cfg_intv | input | CW (8) | Calibration interval, in units of 50 ticks |
| cfg_hold | input | 1 | 1 freezes automatic tracking |
| cfg_eoc_mask | input | 1 | 1 masks the interrupt output |
| req_uncond | input | 1 | Strobe: request unconditional recalibration |
| req_cond | input | 1 | Strobe: request conditional recalibration |
| eoc_clr | input | 1 | Strobe: clear the event flag |
| touch | output | NCH (3) | Per-channel touch flags |
| base_raw | output | NCH*VW (21) | Baselines in the raw domain (127 minus working baseline) |
| req_uncond_pend | output | 1 | Unconditional request pending |
| req_cond_pend | output | 1 | Conditional request pending |
| eoc_pulse | output | 1 | One-cycle end-of-calibration pulse |
| eoc_flag | output | 1 | Sticky end-of-calibration flag |
| eoc_irq | output | 1 | Flag gated by the mask |

## Verification
The comparator is driven with readings that put one channel just above its touch margin, one exactly on it and one inside the band between the two margins, so the strict inequality and the band freeze can be told apart. Small rises are applied both before and after the quiet period has run out, which separates drift absorbed at a calibration point from drift that is wrongly absorbed on every sample. A sample is placed past the time an unrestarted interval timer would fire but before a restarted quiet period ends, which shows whether a touch really restarts the wait. Forced requests are tried with a touched sample, an untouched sample and while not frozen, to separate the conditional, unconditional and ignored paths.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    CK_NONE = 3'd0,
    CK_INIT = 3'd1,
    CK_AUTO = 3'd2,
    CK_UNC  = 3'd3,
    CK_COND = 3'd4
  } cal_kind_e;
endpackage

// File: rtl/cal_chan.sv
module cal_chan
  import cal_pkg::*;
#(
  parameter int VW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [VW-1:0] raw,
  input  logic [VW-1:0] tvr,
  input  logic [VW-1:0] evr,
  input  logic          hold,
  input  cal_kind_e     kind,
  output logic          touch_now,
  output logic          touch_q,
  output logic [VW-1:0] base_q
);
  localparam logic [VW-1:0] FULL = '1;

  logic [VW-1:0] work;
  logic [VW:0]   lim_touch;
  logic [VW:0]   lim_env;
  logic          in_env;
  logic          below;
  logic [VW-1:0] base_d;
  logic          touch_d;

  always_comb begin
    work      = FULL - raw;
    lim_touch = {1'b0, base_q} + {1'b0, tvr};
    lim_env   = {1'b0, base_q} + {1'b0, evr};
    touch_now = ({1'b0, work} > lim_touch);
    in_env    = ({1'b0, work} <= lim_env);
    below     = (work < base_q);
  end

  always_comb begin
    base_d  = base_q;
    touch_d = touch_q;
    if (smp_valid) begin
      touch_d = (kind == CK_INIT) ? 1'b0 : touch_now;
      unique case (kind)
        CK_INIT, CK_UNC, CK_COND: base_d = work;
        CK_AUTO: if (in_env) base_d = work;
        default: if (!hold && below) base_d = work;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      touch_q <= 1'b0;
    end else begin
      base_q  <= base_d;
      touch_q <= touch_d;
    end
  end

  // R3: above the environmental band nothing but a forced load moves the baseline
  p_band_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (kind == CK_NONE || kind == CK_AUTO) && ({1'b0, work} > lim_env))
      |=> (base_q == $past(base_q)));

  // R4: a drop below the baseline is followed at once
  p_snap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && kind == CK_NONE && !hold && (work < base_q))
      |=> (base_q == $past(FULL - raw)));

  // R1: the first sample never reports a touch
  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && kind == CK_INIT) |=> !touch_q);
endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CW       = 8,
  parameter int WAIT_MUL = 64,
  parameter int INTV_MUL = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  input  logic          busy,
  input  logic          consume,
  input  logic [CW-1:0] cfg_wait,
  input  logic [CW-1:0] cfg_intv,
  output logic          due
);
  localparam int WMAX = ((1 << CW) - 1) * WAIT_MUL;
  localparam int IMAX = ((1 << CW) - 1) * INTV_MUL;
  localparam int TMAX = (WMAX > IMAX) ? WMAX : IMAX;
  localparam int TW   = $clog2(TMAX + 1);

  logic [TW-1:0] wlim, ilim, wnext, inext;
  logic [TW-1:0] wcnt_q, wcnt_d, icnt_q, icnt_d;
  logic          waited_q, waited_d, due_q, due_d;

  always_comb begin
    wlim  = TW'(cfg_wait) * TW'(WAIT_MUL);
    ilim  = TW'(cfg_intv) * TW'(INTV_MUL);
    wnext = wcnt_q + TW'(1);
    inext = icnt_q + TW'(1);
  end

  always_comb begin
    wcnt_d   = wcnt_q;
    icnt_d   = icnt_q;
    waited_d = waited_q;
    due_d    = due_q && !consume;
    if (hold || busy) begin
      wcnt_d   = '0;
      icnt_d   = '0;
      waited_d = 1'b0;
      due_d    = 1'b0;
    end else if (tick) begin
      if (!waited_q) begin
        if (wnext >= wlim) begin
          waited_d = 1'b1;
          due_d    = 1'b1;
          wcnt_d   = '0;
          icnt_d   = '0;
        end else begin
          wcnt_d = wnext;
        end
      end else begin
        if (inext >= ilim) begin
          due_d  = 1'b1;
          icnt_d = '0;
        end else begin
          icnt_d = inext;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      icnt_q   <= '0;
      waited_q <= 1'b0;
      due_q    <= 1'b0;
    end else begin
      wcnt_q   <= wcnt_d;
      icnt_q   <= icnt_d;
      waited_q <= waited_d;
      due_q    <= due_d;
    end
  end

  assign due = due_q;

  // R6: a touched channel cancels any due automatic point
  p_touch_cancels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !due);

  // R8: freezing leaves nothing due
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !due);

  // R6: the quiet counter never runs past its limit
  p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!waited_q && $stable(cfg_wait)) |-> (wcnt_q <= wlim));
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_valid,
  input  logic      hit_now,
  input  logic      hold,
  input  logic      due,
  input  logic      req_u,
  input  logic      req_c,
  input  logic      clr,
  input  logic      mask,
  output cal_kind_e kind,
  output logic      consume,
  output logic      pend_u,
  output logic      pend_c,
  output logic      eoc_pulse,
  output logic      eoc_flag,
  output logic      eoc_irq
);
  logic seen_q, seen_d;
  logic pu_q, pu_d, pc_q, pc_d;
  logic pulse_q, pulse_d, flag_q, flag_d;
  logic cal_go, done_u, done_c;

  always_comb begin
    if (!seen_q)                kind = CK_INIT;
    else if (pu_q)              kind = CK_UNC;
    else if (pc_q && !hit_now)  kind = CK_COND;
    else if (!hold && due)      kind = CK_AUTO;
    else                        kind = CK_NONE;
  end

  always_comb begin
    cal_go  = smp_valid && (kind == CK_AUTO || kind == CK_UNC || kind == CK_COND);
    consume = smp_valid && (kind == CK_AUTO);
    done_u  = smp_valid && (kind == CK_UNC);
    done_c  = smp_valid && (kind == CK_UNC || kind == CK_COND);
    seen_d  = seen_q || smp_valid;
    pu_d    = hold && (req_u || (pu_q && !done_u));
    pc_d    = hold && (req_c || (pc_q && !done_c));
    pulse_d = cal_go;
    flag_d  = cal_go || (flag_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      pu_q    <= 1'b0;
      pc_q    <= 1'b0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      pu_q    <= pu_d;
      pc_q    <= pc_d;
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign pend_u    = pu_q;
  assign pend_c    = pc_q;
  assign eoc_pulse = pulse_q;
  assign eoc_flag  = flag_q;
  assign eoc_irq   = flag_q && !mask;

  // R9: a pending forced load is used up by the next sample
  p_uncond_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pu_q && seen_q && !req_u) |=> !pend_u);

  // R10: a touched sample keeps the conditional request waiting
  p_cond_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pc_q && !pu_q && seen_q && hit_now && hold) |=> pend_c);

  // R11: every pulse comes with the sticky flag
  p_flag_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> eoc_flag);

  // R11: a clear with no new event empties the flag
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cal_go) |=> !eoc_flag);
endmodule

// File: rtl/cap_base_cal.sv
module cap_base_cal
  import cal_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int VW       = 7,
  parameter int CW       = 8,
  parameter int WAIT_MUL = 64,
  parameter int INTV_MUL = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [NCH*VW-1:0] smp_raw,
  input  logic              sens_tick,
  input  logic [NCH*VW-1:0] cfg_tvr,
  input  logic [VW-1:0]     cfg_evr,
  input  logic [CW-1:0]     cfg_wait,
  input  logic [CW-1:0]     cfg_intv,
  input  logic              cfg_hold,
  input  logic              cfg_eoc_mask,
  input  logic              req_uncond,
  input  logic              req_cond,
  input  logic              eoc_clr,
  output logic [NCH-1:0]    touch,
  output logic [NCH*VW-1:0] base_raw,
  output logic              req_uncond_pend,
  output logic              req_cond_pend,
  output logic              eoc_pulse,
  output logic              eoc_flag,
  output logic              eoc_irq
);
  localparam logic [VW-1:0] FULL = '1;

  logic [1:0]     rs_q;
  logic           srst_n;
  logic [NCH-1:0] hit_vec;
  logic [VW-1:0]  base_w [NCH];
  cal_kind_e      kind;
  logic           due, consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cal_chan #(.VW(VW)) u_ch (
      .clk       (clk),
      .rst_n     (srst_n),
      .smp_valid (smp_valid),
      .raw       (smp_raw[c*VW +: VW]),
      .tvr       (cfg_tvr[c*VW +: VW]),
      .evr       (cfg_evr),
      .hold      (cfg_hold),
      .kind      (kind),
      .touch_now (hit_vec[c]),
      .touch_q   (touch[c]),
      .base_q    (base_w[c])
    );
    assign base_raw[c*VW +: VW] = FULL - base_w[c];
  end

  cal_timer #(.CW(CW), .WAIT_MUL(WAIT_MUL), .INTV_MUL(INTV_MUL)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (sens_tick),
    .hold     (cfg_hold),
    .busy     (|touch),
    .consume  (consume),
    .cfg_wait (cfg_wait),
    .cfg_intv (cfg_intv),
    .due      (due)
  );

  cal_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (srst_n),
    .smp_valid (smp_valid),
    .hit_now   (|hit_vec),
    .hold      (cfg_hold),
    .due       (due),
    .req_u     (req_uncond),
    .req_c     (req_cond),
    .clr       (eoc_clr),
    .mask      (cfg_eoc_mask),
    .kind      (kind),
    .consume   (consume),
    .pend_u    (req_uncond_pend),
    .pend_c    (req_cond_pend),
    .eoc_pulse (eoc_pulse),
    .eoc_flag  (eoc_flag),
    .eoc_irq   (eoc_irq)
  );

  // R8: while frozen, an event needs a pending host request
  p_frozen_event_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_hold && $past(cfg_hold) && eoc_pulse) |-> ($past(req_uncond_pend) || $past(req_cond_pend)));
endmodule

// File: tb/tb_cap_base_cal.sv
`timescale 1ns/1ps
module tb_cap_base_cal;
  localparam int K_NONE = 0, K_INIT = 1, K_AUTO = 2, K_HOST = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [20:0] smp_raw;
  logic [20:0] cfg_tvr;
  logic [6:0]  cfg_evr;
  logic [7:0]  cfg_wait, cfg_intv;
  logic        cfg_hold, cfg_eoc_mask, req_uncond, req_cond, eoc_clr;
  logic [2:0]  touch;
  logic [20:0] base_raw;
  logic        req_uncond_pend, req_cond_pend, eoc_pulse, eoc_flag, eoc_irq;

  always #2 clk = ~clk;

  cap_base_cal dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_raw(smp_raw),
    .sens_tick(1'b1), .cfg_tvr(cfg_tvr), .cfg_evr(cfg_evr), .cfg_wait(cfg_wait),
    .cfg_intv(cfg_intv), .cfg_hold(cfg_hold), .cfg_eoc_mask(cfg_eoc_mask),
    .req_uncond(req_uncond), .req_cond(req_cond), .eoc_clr(eoc_clr),
    .touch(touch), .base_raw(base_raw), .req_uncond_pend(req_uncond_pend),
    .req_cond_pend(req_cond_pend), .eoc_pulse(eoc_pulse), .eoc_flag(eoc_flag),
    .eoc_irq(eoc_irq)
  );

  typedef struct packed {
    logic [2:0]  t;
    logic [20:0] b;
    logic        e;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    ended = 0;
  int    mb[3];
  int    tv[3] = '{10, 20, 30};

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: model the expected outcome from the requirements, queue it, strobe
  task automatic smp(input logic [6:0] r0, input logic [6:0] r1, input logic [6:0] r2,
                     input int kind, input string tag);
    exp_t x;
    int   r[3];
    r[0] = r0; r[1] = r1; r[2] = r2;
    x.e = (kind == K_AUTO || kind == K_HOST);
    for (int c = 0; c < 3; c++) begin
      int w;
      int nb;
      w  = 127 - r[c];
      x.t[c] = (kind == K_INIT) ? 1'b0 : (w > mb[c] + tv[c]);
      nb = mb[c];
      if (kind == K_INIT || kind == K_HOST) nb = w;
      else if (kind == K_AUTO) begin
        if (w <= mb[c] + int'(cfg_evr)) nb = w;
      end else if (!cfg_hold && w < mb[c]) nb = w;
      mb[c] = nb;
      x.b[c*7 +: 7] = 7'(127 - nb);
    end
    exp_q.push_back(x);
    tag_q.push_back(tag);
    smp_raw   = {r2, r1, r0};
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // monitor: compare each sample result one clock after its strobe
  initial begin
    forever begin
      @(posedge clk);
      if (smp_valid) begin
        exp_t  x;
        string tg;
        @(negedge clk);
        x  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check({tg, " touch"}, int'(touch), int'(x.t));
        check({tg, " base"},  int'(base_raw), int'(x.b));
        check({tg, " eoc_pulse"}, int'(eoc_pulse), int'(x.e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_raw = '0;
    cfg_tvr = {7'd30, 7'd20, 7'd10}; cfg_evr = 7'd4;
    cfg_wait = 8'd1; cfg_intv = 8'd1;
    cfg_hold = 1'b0; cfg_eoc_mask = 1'b0;
    req_uncond = 1'b0; req_cond = 1'b0; eoc_clr = 1'b0;
    for (int c = 0; c < 3; c++) mb[c] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    check("R1 reset touch", int'(touch), 0);
    check("R1 reset base", int'(base_raw), int'({7'd127, 7'd127, 7'd127}));
    check("R1 reset flag", int'(eoc_flag), 0);
    check("R1 reset pulse", int'(eoc_pulse), 0);
    check("R1 reset pend", int'({req_uncond_pend, req_cond_pend}), 0);

    // R1 first sample loads the baselines
    smp(7'd100, 7'd90, 7'd80, K_INIT, "R1 first load");
    // R2 touch just above margin, exactly on margin; R3 inside band
    smp(7'd89, 7'd70, 7'd75, K_NONE, "R2 R3 margins");
    // quiet sample starts the wait
    smp(7'd100, 7'd90, 7'd80, K_NONE, "R6 quiet start");
    idle(30);
    // R5 small rises before any calibration point: no change
    smp(7'd97, 7'd86, 7'd75, K_NONE, "R5 drift early");
    idle(50);
    // R6 quiet period done: automatic calibration absorbs drift, band frozen
    smp(7'd97, 7'd86, 7'd75, K_AUTO, "R6 R5 first auto");
    check("R11 flag set", int'(eoc_flag), 1);
    check("R11 irq unmasked", int'(eoc_irq), 1);
    // R4 drop below baseline follows at once
    smp(7'd102, 7'd86, 7'd75, K_NONE, "R4 snap down");
    idle(15);
    smp(7'd102, 7'd85, 7'd75, K_NONE, "R7 before interval");
    idle(30);
    smp(7'd102, 7'd85, 7'd75, K_AUTO, "R7 interval auto");
    // R11 clear
    eoc_clr = 1'b1; @(negedge clk); eoc_clr = 1'b0;
    check("R11 cleared", int'(eoc_flag), 0);

    // R6 touch restarts the wait
    smp(7'd87, 7'd85, 7'd80, K_NONE, "R6 touch restart");
    smp(7'd102, 7'd85, 7'd80, K_NONE, "R6 quiet again");
    cfg_eoc_mask = 1'b1;
    idle(44);
    smp(7'd102, 7'd84, 7'd80, K_NONE, "R6 no early auto");
    idle(34);
    smp(7'd102, 7'd84, 7'd80, K_AUTO, "R6 auto after restart");
    check("R11 flag masked", int'(eoc_flag), 1);
    check("R11 irq masked", int'(eoc_irq), 0);
    cfg_eoc_mask = 1'b0;
    @(negedge clk);
    check("R11 irq unmask", int'(eoc_irq), 1);
    eoc_clr = 1'b1; @(negedge clk); eoc_clr = 1'b0;

    // R8 freeze
    cfg_hold = 1'b1;
    @(negedge clk);
    smp(7'd110, 7'd84, 7'd80, K_NONE, "R8 no snap");
    idle(150);
    smp(7'd102, 7'd83, 7'd80, K_NONE, "R8 no auto");
    check("R8 flag quiet", int'(eoc_flag), 0);

    // R9 unconditional request
    req_uncond = 1'b1; @(negedge clk); req_uncond = 1'b0;
    check("R9 pend set", int'(req_uncond_pend), 1);
    smp(7'd62, 7'd60, 7'd50, K_HOST, "R9 forced load");
    check("R9 pend clear", int'(req_uncond_pend), 0);

    // R10 conditional request
    req_cond = 1'b1; @(negedge clk); req_cond = 1'b0;
    check("R10 pend set", int'(req_cond_pend), 1);
    smp(7'd62, 7'd35, 7'd50, K_NONE, "R10 touched wait");
    check("R10 still pend", int'(req_cond_pend), 1);
    smp(7'd64, 7'd61, 7'd52, K_HOST, "R10 quiet load");
    check("R10 pend clear", int'(req_cond_pend), 0);

    // R9 request ignored when not frozen
    cfg_hold = 1'b0;
    @(negedge clk);
    req_uncond = 1'b1; @(negedge clk); req_uncond = 1'b0;
    check("R9 ignored unfrozen", int'(req_uncond_pend), 0);

    idle(3);
    finish_run();
  end
endmodule